// File: doc/BRIEF.md
# Reference Divider, Phase-Frequency Comparator and Lock Monitor

This block forms the comparison side of a frequency synthesizer loop. A free-running counter divides the reference clock by one of three ratios to make a reference tick. A dual flip-flop phase-frequency comparator weighs that tick against the divided VCO pulse. Its up/down state drives the enables of an external charge pump: source, sink, or neither (high impedance). A lock monitor watches the width of each comparison error. It declares lock after a run of narrow errors and drops it on the first wide one.

A three-bit test-mode field can override the pump. It can hold the pump at high impedance, or force it to sink or to source. It also chooses what the test/lock pin carries: the lock flag, a square copy of the reference, or the divided VCO pulse. Two further control bits pass through registered: the pump current select and the tuning-amplifier enable. All outputs are registered and reset synchronously.

The divided VCO input is a single-cycle pulse in the reference clock domain. The analog pump and the tuning amplifier sit outside this block.

Top module: `synth_phase_core`

## Requirements
- R1: While `rst` is high, on each rising edge the outputs take these values: both pump enables 0, `cur_hi_o` 1, `tune_en_o` 0 and `ld_test_o` 1. The lock flag is set.
- R2: The reference divider restarts at count 0 after reset and counts one step per clock. Its ratio comes from `ratio_sel_i`. With bit1=0 the ratio is DIV_MID, whatever bit0 holds. With bit1=1 and bit0=1 it is DIV_SHORT. With bit1=1 and bit0=0 it is DIV_LONG. The tick fires in the cycle the count equals ratio-1, and the count then wraps to 0. The square reference is high while the count is below ratio/2.
- R3: A divided pulse that arrives before the reference tick sets the up state, which holds until the tick. A tick that arrives first sets the down state, which holds until the divided pulse. When both events are present in one cycle, both states clear. The pump enables follow the up/down state two clock edges after the input pulse.
- R4: Further pulses from the leading input, while its state is already set, leave the state set. The comparator therefore also reports frequency error.
- R5: With `tmode_i[2:1]`=00 the pump follows the comparator, and `ld_test_o` shows the lock flag one edge later.
- R6: With `tmode_i[2:1]`=01 both pump enables are 0, and `ld_test_o` shows the lock flag.
- R7: With `tmode_i[2:1]`=11, `tmode_i[0]`=0 forces sink (`pump_dn_o`=1, `pump_up_o`=0) and `tmode_i[0]`=1 forces source. `ld_test_o` shows the lock flag.
- R8: With `tmode_i[2:1]`=10 both pump enables are 0. `ld_test_o` shows the square reference when `tmode_i[0]`=0 and the registered divided pulse when it is 1.
- R9: `cur_hi_o` equals `cur_hi_i` and `tune_en_o` equals the inverse of `tune_off_i`, each one edge later.
- R10: A comparison ends when the up and down events meet. If its error lasted at most LOCK_TOL cycles between the two pulses, it counts as narrow. After LOCK_RUN narrow comparisons in a row, the lock flag sets.
- R11: The lock flag clears on the edge where an open error reaches LOCK_TOL+1 cycles, even before the comparison ends. The run of narrow comparisons then restarts from zero.
- R12: If the ratio changes while the count is above the new ratio-1, the count returns to 0 on the next edge and no tick fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fdiv_i | input | 1 | Divided VCO pulse, one cycle wide |
| tmode_i | input | 3 | Test-mode field |
| ratio_sel_i | input | 2 | Reference ratio select |
| cur_hi_i | input | 1 | Pump current select, 1 = high current |
| tune_off_i | input | 1 | 1 disables the tuning amplifier |
| pump_up_o | output | 1 | Pump source enable |
| pump_dn_o | output | 1 | Pump sink enable |
| cur_hi_o | output | 1 | Registered current select |
| tune_en_o | output | 1 | Tuning amplifier enable |
| ld_test_o | output | 1 | Lock flag or test signal |

## Verification
Some properties hold on every cycle, and the assertions check these. The two pump enables are never both high. The forced and high-impedance modes hold the pump as the mode field demands. The current and tuning controls track their inputs with one edge of delay. The pin reads locked straight after reset.

Other behaviours depend on history, and only the bench's scenarios can show them. These include the lock run count, a lock lost on an open wide error, the frequency-detect hold on repeated pulses, the divider wrap when the ratio shrinks, and the exact phase of the square reference. The bench exercises these with placed lead and lag offsets against a cycle model.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    PUMP_FOLLOW = 2'd0,
    PUMP_HIZ    = 2'd1,
    PUMP_SINK   = 2'd2,
    PUMP_SRC    = 2'd3
  } pump_mode_e;

  typedef enum logic [1:0] {
    PIN_LOCK = 2'd0,
    PIN_REF  = 2'd1,
    PIN_DIV  = 2'd2
  } pin_sel_e;

  typedef struct packed {
    pump_mode_e pump;
    pin_sel_e   pin;
  } mode_cfg_t;

  // Test-mode decode: bits [2:1] pick the class, bit 0 refines it.
  function automatic mode_cfg_t decode_tmode(input logic [2:0] t);
    mode_cfg_t c;
    unique case (t[2:1])
      2'b00: begin c.pump = PUMP_FOLLOW; c.pin = PIN_LOCK; end
      2'b01: begin c.pump = PUMP_HIZ;    c.pin = PIN_LOCK; end
      2'b11: begin c.pump = t[0] ? PUMP_SRC : PUMP_SINK; c.pin = PIN_LOCK; end
      default: begin c.pump = PUMP_HIZ; c.pin = t[0] ? PIN_DIV : PIN_REF; end
    endcase
    return c;
  endfunction

  function automatic int imax3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ref_div.sv
module ref_div #(
  parameter int DIV_SHORT = 512,
  parameter int DIV_LONG  = 1024,
  parameter int DIV_MID   = 640
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ratio_sel_i,
  output logic       tick_o,
  output logic       lvl_o
);
  localparam int MAX_DIV = pfd_pkg::imax3(DIV_SHORT, DIV_LONG, DIV_MID);
  localparam int CW      = $clog2(MAX_DIV);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_c;
  logic [CW-1:0] half_c;

  always_comb begin
    if (!ratio_sel_i[1]) begin
      last_c = CW'(DIV_MID - 1);
      half_c = CW'(DIV_MID / 2);
    end else if (ratio_sel_i[0]) begin
      last_c = CW'(DIV_SHORT - 1);
      half_c = CW'(DIV_SHORT / 2);
    end else begin
      last_c = CW'(DIV_LONG - 1);
      half_c = CW'(DIV_LONG / 2);
    end
  end

  // Wrap on >= so a ratio that shrinks below the count restarts cleanly.
  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (cnt_q >= last_c) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == last_c);
  assign lvl_o  = (cnt_q < half_c);

endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick_i,
  input  logic div_tick_i,
  output logic up_o,
  output logic dn_o,
  output logic done_o
);
  logic up_q, dn_q;
  logic set_up, set_dn;

  assign set_up = up_q | div_tick_i;
  assign set_dn = dn_q | ref_tick_i;
  assign done_o = set_up & set_dn;

  // Dual flip-flop with reset-on-both: a repeated leading edge only holds state.
  always_ff @(posedge clk) begin
    if (rst || done_o) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= set_up;
      dn_q <= set_dn;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

endmodule

// File: rtl/lock_mon.sv
module lock_mon #(
  parameter int LOCK_TOL = 2,
  parameter int LOCK_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  input  logic done_i,
  output logic lock_o
);
  localparam int EW = $clog2(LOCK_TOL + 1);
  localparam int SW = $clog2(LOCK_RUN + 1);

  logic [EW-1:0] err_q;
  logic [SW-1:0] run_q;
  logic          lock_q;
  logic          wide, narrow;

  assign wide   = act_i && (err_q >= EW'(LOCK_TOL));
  assign narrow = done_i && !wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0;
    end else if (done_i) begin
      err_q <= '0;
    end else if (act_i && (err_q < EW'(LOCK_TOL))) begin
      err_q <= err_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      lock_q <= 1'b1;
    end else if (wide) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (narrow) begin
      if (run_q >= SW'(LOCK_RUN - 1)) lock_q <= 1'b1;
      if (run_q < SW'(LOCK_RUN))      run_q  <= run_q + 1'b1;
    end
  end

  assign lock_o = lock_q;

endmodule

// File: rtl/pump_out_mux.sv
module pump_out_mux
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] tmode_i,
  input  logic       up_i,
  input  logic       dn_i,
  input  logic       ref_lvl_i,
  input  logic       div_tick_i,
  input  logic       lock_i,
  input  logic       cur_hi_i,
  input  logic       tune_off_i,
  output logic       pump_up_o,
  output logic       pump_dn_o,
  output logic       cur_hi_o,
  output logic       tune_en_o,
  output logic       pin_o
);
  mode_cfg_t cfg;
  logic      nxt_up, nxt_dn, nxt_pin;

  assign cfg = decode_tmode(tmode_i);

  always_comb begin
    unique case (cfg.pump)
      PUMP_FOLLOW: begin nxt_up = up_i; nxt_dn = dn_i; end
      PUMP_SINK:   begin nxt_up = 1'b0; nxt_dn = 1'b1; end
      PUMP_SRC:    begin nxt_up = 1'b1; nxt_dn = 1'b0; end
      default:     begin nxt_up = 1'b0; nxt_dn = 1'b0; end
    endcase
    unique case (cfg.pin)
      PIN_REF: nxt_pin = ref_lvl_i;
      PIN_DIV: nxt_pin = div_tick_i;
      default: nxt_pin = lock_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_up_o <= 1'b0;
      pump_dn_o <= 1'b0;
      cur_hi_o  <= 1'b1;
      tune_en_o <= 1'b0;
      pin_o     <= 1'b1;
    end else begin
      pump_up_o <= nxt_up;
      pump_dn_o <= nxt_dn;
      cur_hi_o  <= cur_hi_i;
      tune_en_o <= !tune_off_i;
      pin_o     <= nxt_pin;
    end
  end

endmodule

// File: rtl/synth_phase_core.sv
module synth_phase_core #(
  parameter int DIV_SHORT = 512,
  parameter int DIV_LONG  = 1024,
  parameter int DIV_MID   = 640,
  parameter int LOCK_TOL  = 2,
  parameter int LOCK_RUN  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fdiv_i,
  input  logic [2:0] tmode_i,
  input  logic [1:0] ratio_sel_i,
  input  logic       cur_hi_i,
  input  logic       tune_off_i,
  output logic       pump_up_o,
  output logic       pump_dn_o,
  output logic       cur_hi_o,
  output logic       tune_en_o,
  output logic       ld_test_o
);
  logic ref_tick, ref_lvl;
  logic up_s, dn_s, done_s;
  logic lock_s;

  ref_div #(
    .DIV_SHORT(DIV_SHORT), .DIV_LONG(DIV_LONG), .DIV_MID(DIV_MID)
  ) i_ref_div (
    .clk(clk), .rst(rst), .ratio_sel_i(ratio_sel_i),
    .tick_o(ref_tick), .lvl_o(ref_lvl)
  );

  pfd_core i_pfd (
    .clk(clk), .rst(rst), .ref_tick_i(ref_tick), .div_tick_i(fdiv_i),
    .up_o(up_s), .dn_o(dn_s), .done_o(done_s)
  );

  lock_mon #(.LOCK_TOL(LOCK_TOL), .LOCK_RUN(LOCK_RUN)) i_lock (
    .clk(clk), .rst(rst), .act_i(up_s | dn_s), .done_i(done_s),
    .lock_o(lock_s)
  );

  pump_out_mux i_mux (
    .clk(clk), .rst(rst), .tmode_i(tmode_i), .up_i(up_s), .dn_i(dn_s),
    .ref_lvl_i(ref_lvl), .div_tick_i(fdiv_i), .lock_i(lock_s),
    .cur_hi_i(cur_hi_i), .tune_off_i(tune_off_i),
    .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o), .cur_hi_o(cur_hi_o),
    .tune_en_o(tune_en_o), .pin_o(ld_test_o)
  );

endmodule

// File: rtl/synth_phase_chk.sv
module synth_phase_chk (
  input logic       clk,
  input logic       rst,
  input logic       fdiv_i,
  input logic [2:0] tmode_i,
  input logic [1:0] ratio_sel_i,
  input logic       cur_hi_i,
  input logic       tune_off_i,
  input logic       pump_up_o,
  input logic       pump_dn_o,
  input logic       cur_hi_o,
  input logic       tune_en_o,
  input logic       ld_test_o
);
  // R3: source and sink are never enabled together
  p_no_both_r3: assert property (@(posedge clk) disable iff (rst)
    !(pump_up_o && pump_dn_o));

  // R6: high-impedance class holds both enables low
  p_hiz_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(tmode_i[2:1]) == 2'b01) |-> (!pump_up_o && !pump_dn_o));

  // R7: forced sink
  p_sink_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tmode_i) == 3'b110) |-> (pump_dn_o && !pump_up_o));

  // R7: forced source
  p_source_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tmode_i) == 3'b111) |-> (pump_up_o && !pump_dn_o));

  // R8: test-output class keeps the pump idle
  p_testpin_hiz_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(tmode_i[2:1]) == 2'b10) |-> (!pump_up_o && !pump_dn_o));

  // R9: current select and tuning enable track their controls
  p_cur_track_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cur_hi_o == $past(cur_hi_i)));
  p_tune_track_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tune_en_o == !$past(tune_off_i)));

  // R1: the pin reads locked on the first cycle out of reset
  p_lock_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ld_test_o && !pump_up_o && !pump_dn_o));

endmodule

bind synth_phase_core synth_phase_chk i_chk (.*);

// File: tb/test_synth_phase_core.sv
`timescale 1ns/1ps
module test_synth_phase_core;
  localparam int DS = 12, DL = 24, DM = 20, TOL = 2, RUN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fdiv = 1'b0;
  logic [2:0] tmode = 3'b000;
  logic [1:0] rsel = 2'b11;
  logic cur_hi = 1'b1, tune_off = 1'b0;
  logic pump_up, pump_dn, cur_o, tune_o, pin_o;

  always #4 clk = ~clk;

  synth_phase_core #(.DIV_SHORT(DS), .DIV_LONG(DL), .DIV_MID(DM),
                     .LOCK_TOL(TOL), .LOCK_RUN(RUN)) i_synth_phase_core (
    .clk(clk), .rst(rst), .fdiv_i(fdiv), .tmode_i(tmode), .ratio_sel_i(rsel),
    .cur_hi_i(cur_hi), .tune_off_i(tune_off), .pump_up_o(pump_up),
    .pump_dn_o(pump_dn), .cur_hi_o(cur_o), .tune_en_o(tune_o), .ld_test_o(pin_o));

  int n_cmp = 0, n_bad = 0;
  string pump_tag = "R3", pin_tag = "R5";

  // Ratio per R2 encoding
  function automatic int f_ratio(input logic [1:0] s);
    if (!s[1]) return DM;
    return s[0] ? DS : DL;
  endfunction

  // Expected pump enables per R5..R8
  function automatic logic [1:0] f_pump(input logic [2:0] t, input logic u, input logic d);
    case (t[2:1])
      2'b00: return {u, d};
      2'b11: return t[0] ? 2'b10 : 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic f_pin(input logic [2:0] t, input logic lk, input logic lv, input logic fd);
    if (t[2:1] != 2'b10) return lk;
    return t[0] ? fd : lv;
  endfunction

  // Cycle model built from the requirements
  int   m_cnt = 0, m_err = 0, m_run = 0;
  logic m_up = 0, m_dn = 0, m_lock = 1, m_rst_seen = 1;
  logic e_up = 0, e_dn = 0, e_cur = 1, e_tune = 0, e_pin = 1;

  always @(posedge clk) begin
    int r; logic tick, lvl, su, sd, meet, act, wide;
    logic [1:0] pp;
    r = f_ratio(rsel);
    tick = (m_cnt == r - 1);
    lvl = (m_cnt < r / 2);
    su = m_up | fdiv; sd = m_dn | tick; meet = su & sd;
    act = m_up | m_dn; wide = act && (m_err >= TOL);
    m_rst_seen <= rst;
    if (rst) begin
      m_cnt <= 0; m_up <= 0; m_dn <= 0; m_err <= 0; m_run <= 0; m_lock <= 1;
      e_up <= 0; e_dn <= 0; e_cur <= 1; e_tune <= 0; e_pin <= 1;
    end else begin
      m_cnt <= (m_cnt >= r - 1) ? 0 : m_cnt + 1;
      m_up <= meet ? 1'b0 : su;
      m_dn <= meet ? 1'b0 : sd;
      if (meet) m_err <= 0; else if (act && m_err < TOL) m_err <= m_err + 1;
      if (wide) begin m_run <= 0; m_lock <= 0; end
      else if (meet) begin
        if (m_run >= RUN - 1) m_lock <= 1;
        if (m_run < RUN) m_run <= m_run + 1;
      end
      pp = f_pump(tmode, m_up, m_dn);
      e_up <= pp[1]; e_dn <= pp[0];
      e_cur <= cur_hi; e_tune <= !tune_off;
      e_pin <= f_pin(tmode, m_lock, lvl, fdiv);
    end
  end

  task automatic chk(input string tag, input string nm, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, nm, got, exp, $time);
    end
  endtask

  // Sample outputs 2 ns after each rising edge
  always @(posedge clk) begin
    string tp, tq, tc;
    #2;
    tp = m_rst_seen ? "R1" : pump_tag;
    tq = m_rst_seen ? "R1" : pin_tag;
    tc = m_rst_seen ? "R1" : "R9";
    chk(tp, "pump_up", pump_up, e_up);
    chk(tp, "pump_dn", pump_dn, e_dn);
    chk(tc, "cur_hi", cur_o, e_cur);
    chk(tc, "tune_en", tune_o, e_tune);
    chk(tq, "ld_test", pin_o, e_pin);
  end

  // Divided-pulse policy: 0 none, 1 lead by off, 2 lag by off, 3 random, 4 double lead
  int pol = 0, off = 1, off2 = 4;
  always @(negedge clk) begin
    int last;
    last = f_ratio(rsel) - 1;
    case (pol)
      1: fdiv = (m_cnt == last - off);
      2: fdiv = (m_cnt == off - 1);
      3: fdiv = ($urandom % 9) == 0;
      4: fdiv = (m_cnt == last - off) || (m_cnt == last - off2);
      default: fdiv = 1'b0;
    endcase
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5A17);
    pump_tag = "R1"; pin_tag = "R1";
    run(4);
    rst = 0;
    // R10 / R3: narrow lead keeps lock, pump sources during lead
    pump_tag = "R3"; pin_tag = "R10";
    pol = 1; off = 1; run(DS * 6);
    // R11: wide lead clears lock
    pin_tag = "R11"; off = 5; run(DS * 3);
    // R10: phase match re-declares lock after the run
    pin_tag = "R10"; off = 0; run(DS * 6);
    // R3 lag: reference first gives sink; wide lag clears lock (R11)
    pin_tag = "R11"; pol = 2; off = 4; run(DS * 3);
    pin_tag = "R10"; off = 2; run(DS * 6);
    // R4: two leading pulses per period keep the up state held
    pump_tag = "R4"; pin_tag = "R11"; pol = 4; off = 2; off2 = 6; run(DS * 4);
    // R6 / R7 forced modes
    pol = 3;
    pump_tag = "R6"; pin_tag = "R5"; tmode = 3'b010; run(40); tmode = 3'b011; run(40);
    pump_tag = "R7"; tmode = 3'b110; run(40); tmode = 3'b111; run(40);
    // R8 / R2: reference square for every ratio
    pump_tag = "R8"; pin_tag = "R2"; tmode = 3'b100;
    for (int k = 0; k < 4; k++) begin
      rsel = 2'(k); run(DL * 3);
    end
    pin_tag = "R8"; tmode = 3'b101; run(60);
    // R12: shrink the ratio while the count is above the new limit
    pin_tag = "R12"; tmode = 3'b100; rsel = 2'b10;
    while (m_cnt != 18) @(negedge clk);
    rsel = 2'b11; run(DS * 3);
    // R9 and a random mix of everything
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cur_hi = 1'($urandom); tune_off = 1'($urandom);
      if (($urandom % 64) == 0) begin
        tmode = 3'($urandom); rsel = 2'($urandom);
      end
      case (tmode[2:1])
        2'b00: begin pump_tag = "R3"; pin_tag = "R5"; end
        2'b01: begin pump_tag = "R6"; pin_tag = "R5"; end
        2'b11: begin pump_tag = "R7"; pin_tag = "R5"; end
        default: begin pump_tag = "R8"; pin_tag = "R8"; end
      endcase
    end
    // R1: reset in mid-run
    @(negedge clk); rst = 1; run(2); rst = 0; pol = 0; run(10);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule